// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Mirrors

This block gathers level-sensitive interrupt requests from three banks: a small bank of 8 direct sources and two wide banks of 32 sources each. Every source has its own mask bit, which software sets through a write-one-to-set register and clears through a write-one-to-clear register. A bank's pending word is the live request level ANDed with its mask. Nothing is latched, so a request disappears as soon as its source drops.

The pending word of the small bank is the entry point for software. Besides its 8 direct bits, it carries one summary bit for each wide bank and a group of mirror bits that copy selected wide-bank sources directly. A wide-bank source that has a mirror bit does not raise its bank's summary bit. Software can therefore read a single word and service those sources without a second read.

A separate fast-interrupt selector routes one chosen source, by its raw level, to a dedicated output. It removes that source from the normal interrupt output. The normal interrupt output is the OR of everything the small bank's pending word reports.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After synchronous reset, all mask bits and the fast selector register are zero. Both `irq_o` and `fast_o` are low, whatever the source levels.
- R2: A write to a set address ORs the data into that bank's mask, and a write to a clear address removes the data's 1 bits from it. The set addresses are 0x18, 0x10 and 0x14 and the clear addresses are 0x24, 0x1C and 0x20, for the small bank, wide bank 1 and wide bank 2 in that order. Reading either address returns the mask. Only bits 7:0 exist for the small bank.
- R3: Reading 0x04 returns wide bank 1's raw levels ANDed with its mask, and reading 0x08 does the same for wide bank 2.
- R4: Bits 7:0 of the word read at 0x00 are the small bank's raw levels ANDed with its mask.
- R5: Bit 8 at 0x00 is set when any masked-in bank 1 source without a mirror is active, and bit 9 does the same for bank 2. Mirrored sources never set these bits.
- R6: Bits 10 to 14 at 0x00 mirror the pending state of bank 1 sources 7, 9, 10, 18 and 19. Bits 15 to 20 mirror bank 2 sources 21, 22, 23, 24, 25 and 30. These bits follow the wide-bank masks only, so writes to the small bank's set or clear address do not change them. Bits 31:21 read zero.
- R7: The fast selector register at 0x0C holds an index in bits 6:0 and an enable in bit 7, and reads back with bits 31:8 zero. Index 0 to 31 selects bank 1 sources, 32 to 63 selects bank 2 sources and 64 to 71 selects small-bank sources 0 to 7.
- R8: `fast_o` is high exactly when the selector is enabled and the selected source's raw level is high, whatever the mask. Indexes 72 to 127 never assert it.
- R9: `irq_o` is high when any bit of the 0x00 word would be set with the currently routed fast source left out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr`, combinational |
| src_b0 | input | 8 | Small-bank request levels |
| src_b1 | input | 32 | Wide bank 1 request levels |
| src_b2 | input | 32 | Wide bank 2 request levels |
| irq_o | output | 1 | Normal interrupt request |
| fast_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that request levels and the register port change only between clock edges, and that the mask-write properties see just one write per cycle. The bench meets both conditions by driving every input on the falling edge, writing one register at a time and holding sources steady across each sampling window. The idle property assumes that a quiet source set means all three source buses are zero. The stimulus creates that state by clearing every source bus before each new pattern.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int B0_SRCS   = 8;
    localparam int BANK_SRCS = 32;
    localparam int SC1_N     = 5;
    localparam int SC2_N     = 6;
    localparam int SEL_W     = 7;
    localparam int IDX_W     = $clog2(BANK_SRCS);
    localparam int B0_IDX_W  = $clog2(B0_SRCS);

    // bit positions inside the small bank's pending word
    localparam int SUM1_BIT  = B0_SRCS;
    localparam int SUM2_BIT  = B0_SRCS + 1;
    localparam int SC1_BASE  = B0_SRCS + 2;
    localparam int SC2_BASE  = SC1_BASE + SC1_N;

    // flat selector index ranges: bank 1, bank 2, then small bank
    localparam int SEL_B2_LO = BANK_SRCS;
    localparam int SEL_B0_LO = 2 * BANK_SRCS;
    localparam int SEL_END   = 2 * BANK_SRCS + B0_SRCS;

    localparam logic [ADDR_W-1:0] A_PEND0 = 6'h00;
    localparam logic [ADDR_W-1:0] A_PEND1 = 6'h04;
    localparam logic [ADDR_W-1:0] A_PEND2 = 6'h08;
    localparam logic [ADDR_W-1:0] A_FAST  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_SET1  = 6'h10;
    localparam logic [ADDR_W-1:0] A_SET2  = 6'h14;
    localparam logic [ADDR_W-1:0] A_SET0  = 6'h18;
    localparam logic [ADDR_W-1:0] A_CLR1  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_CLR2  = 6'h20;
    localparam logic [ADDR_W-1:0] A_CLR0  = 6'h24;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } fast_ctl_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_B0   = 2'd1,
        RT_B1   = 2'd2,
        RT_B2   = 2'd3
    } route_bank_e;

    // bank 1 source mirrored by shortcut slot k
    function automatic int sc1_src(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            default: return 19;
        endcase
    endfunction

    // bank 2 source mirrored by shortcut slot k
    function automatic int sc2_src(input int k);
        case (k)
            0:       return 21;
            1:       return 22;
            2:       return 23;
            3:       return 24;
            4:       return 25;
            default: return 30;
        endcase
    endfunction

    function automatic logic [BANK_SRCS-1:0] sc1_mask();
        logic [BANK_SRCS-1:0] m;
        m = '0;
        for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
        return m;
    endfunction

    function automatic logic [BANK_SRCS-1:0] sc2_mask();
        logic [BANK_SRCS-1:0] m;
        m = '0;
        for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (set_we) en_q <= en_q | wdata;
        else if (clr_we) en_q <= en_q & ~wdata;
    end

    assign pend = src & en_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import banked_irq_pkg::*;
(
    input  logic [B0_SRCS-1:0]   pend0,
    input  logic [BANK_SRCS-1:0] pend1,
    input  logic [BANK_SRCS-1:0] pend2,
    output logic [DATA_W-1:0]    word
);
    localparam logic [BANK_SRCS-1:0] M1 = sc1_mask();
    localparam logic [BANK_SRCS-1:0] M2 = sc2_mask();

    logic [SC1_N-1:0] mir1;
    logic [SC2_N-1:0] mir2;

    for (genvar k = 0; k < SC1_N; k++) begin : g_mir1
        assign mir1[k] = pend1[sc1_src(k)];
    end
    for (genvar k = 0; k < SC2_N; k++) begin : g_mir2
        assign mir2[k] = pend2[sc2_src(k)];
    end

    always_comb begin
        word                           = '0;
        word[B0_SRCS-1:0]              = pend0;
        word[SUM1_BIT]                 = |(pend1 & ~M1);
        word[SUM2_BIT]                 = |(pend2 & ~M2);
        word[SC1_BASE +: SC1_N]        = mir1;
        word[SC2_BASE +: SC2_N]        = mir2;
    end
endmodule

// File: rtl/irq_fast_route.sv
module irq_fast_route
    import banked_irq_pkg::*;
(
    input  fast_ctl_t            ctl,
    input  logic [B0_SRCS-1:0]   src0,
    input  logic [BANK_SRCS-1:0] src1,
    input  logic [BANK_SRCS-1:0] src2,
    output logic [B0_SRCS-1:0]   route0,
    output logic [BANK_SRCS-1:0] route1,
    output logic [BANK_SRCS-1:0] route2,
    output logic                 fast_o
);
    route_bank_e bank;

    always_comb begin
        if (!ctl.en)                               bank = RT_NONE;
        else if (int'(ctl.sel) < SEL_B2_LO)        bank = RT_B1;
        else if (int'(ctl.sel) < SEL_B0_LO)        bank = RT_B2;
        else if (int'(ctl.sel) < SEL_END)          bank = RT_B0;
        else                                       bank = RT_NONE;
    end

    always_comb begin
        route0 = '0;
        route1 = '0;
        route2 = '0;
        case (bank)
            RT_B0:   route0 = B0_SRCS'(1) << ctl.sel[B0_IDX_W-1:0];
            RT_B1:   route1 = BANK_SRCS'(1) << ctl.sel[IDX_W-1:0];
            RT_B2:   route2 = BANK_SRCS'(1) << ctl.sel[IDX_W-1:0];
            default: ;
        endcase
    end

    assign fast_o = |(route0 & src0) | |(route1 & src1) | |(route2 & src2);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import banked_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [B0_SRCS-1:0]   src_b0,
    input  logic [BANK_SRCS-1:0] src_b1,
    input  logic [BANK_SRCS-1:0] src_b2,
    output logic                 irq_o,
    output logic                 fast_o
);
    logic [B0_SRCS-1:0]   en0_q, pend0, route0;
    logic [BANK_SRCS-1:0] en1_q, pend1, route1;
    logic [BANK_SRCS-1:0] en2_q, pend2, route2;
    logic [DATA_W-1:0]    word0, word0_irq;
    fast_ctl_t            fast_ctl_q;

    irq_mask_bank #(.W(B0_SRCS)) u_bank0 (
        .clk(clk), .rst(rst),
        .set_we(wr_en && reg_addr == A_SET0),
        .clr_we(wr_en && reg_addr == A_CLR0),
        .wdata(wr_data[B0_SRCS-1:0]), .src(src_b0),
        .en_q(en0_q), .pend(pend0)
    );

    irq_mask_bank #(.W(BANK_SRCS)) u_bank1 (
        .clk(clk), .rst(rst),
        .set_we(wr_en && reg_addr == A_SET1),
        .clr_we(wr_en && reg_addr == A_CLR1),
        .wdata(wr_data[BANK_SRCS-1:0]), .src(src_b1),
        .en_q(en1_q), .pend(pend1)
    );

    irq_mask_bank #(.W(BANK_SRCS)) u_bank2 (
        .clk(clk), .rst(rst),
        .set_we(wr_en && reg_addr == A_SET2),
        .clr_we(wr_en && reg_addr == A_CLR2),
        .wdata(wr_data[BANK_SRCS-1:0]), .src(src_b2),
        .en_q(en2_q), .pend(pend2)
    );

    always_ff @(posedge clk) begin
        if (rst)                               fast_ctl_q <= '0;
        else if (wr_en && reg_addr == A_FAST)  fast_ctl_q <= wr_data[SEL_W:0];
    end

    irq_fast_route u_route (
        .ctl(fast_ctl_q), .src0(src_b0), .src1(src_b1), .src2(src_b2),
        .route0(route0), .route1(route1), .route2(route2), .fast_o(fast_o)
    );

    // software-visible word
    irq_summary u_sum_rd (
        .pend0(pend0), .pend1(pend1), .pend2(pend2), .word(word0)
    );

    // same word with the fast-routed source removed, feeds irq_o
    irq_summary u_sum_irq (
        .pend0(pend0 & ~route0), .pend1(pend1 & ~route1),
        .pend2(pend2 & ~route2), .word(word0_irq)
    );

    assign irq_o = |word0_irq;

    always_comb begin
        case (reg_addr)
            A_PEND0:         rd_data = word0;
            A_PEND1:         rd_data = pend1;
            A_PEND2:         rd_data = pend2;
            A_FAST:          rd_data = DATA_W'(fast_ctl_q);
            A_SET0, A_CLR0:  rd_data = DATA_W'(en0_q);
            A_SET1, A_CLR1:  rd_data = en1_q;
            A_SET2, A_CLR2:  rd_data = en2_q;
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk
    import banked_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wr_data,
    input logic [B0_SRCS-1:0]   src_b0,
    input logic [BANK_SRCS-1:0] src_b1,
    input logic [BANK_SRCS-1:0] src_b2,
    input logic                 irq_o,
    input logic                 fast_o,
    input logic [BANK_SRCS-1:0] en1_q,
    input logic [SEL_W:0]       fast_ctl
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en1_q == '0 && fast_ctl == '0));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == A_SET1) |=> ((en1_q & $past(wr_data)) == $past(wr_data)));

    p_mask_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == A_CLR1) |=> ((en1_q & $past(wr_data)) == '0));

    p_fast_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !fast_ctl[SEL_W] |-> !fast_o);

    p_fast_range_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(fast_ctl[SEL_W-1:0]) >= SEL_END) |-> !fast_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (src_b0 == '0 && src_b1 == '0 && src_b2 == '0) |-> (!irq_o && !fast_o));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .src_b0(src_b0), .src_b1(src_b1), .src_b2(src_b2),
    .irq_o(irq_o), .fast_o(fast_o), .en1_q(en1_q), .fast_ctl(fast_ctl_q)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  b0;
        logic [31:0] b1;
        logic [31:0] b2;
        logic [31:0] exp0;
    } vec_t;

    // all masks open, fast selector off
    localparam vec_t VECS [10] = '{
        '{8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        '{8'h01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001},
        '{8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
        '{8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
        '{8'h00, 32'h0008_0000, 32'h0000_0000, 32'h0000_4000},
        '{8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
        '{8'h00, 32'h0000_0000, 32'h0020_0001, 32'h0000_8200},
        '{8'h80, 32'h0000_0600, 32'h0000_0000, 32'h0000_1880},
        '{8'h00, 32'h0000_0000, 32'h0000_0002, 32'h0000_0200},
        '{8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h001F_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  src_b0 = '0;
    logic [31:0] src_b1 = '0;
    logic [31:0] src_b2 = '0;
    logic        irq_o, fast_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .src_b0(src_b0),
        .src_b1(src_b1), .src_b2(src_b2), .irq_o(irq_o), .fast_o(fast_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic drive(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
        src_b0 = b0; src_b1 = b1; src_b2 = b2;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, sources high but nothing open
        drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_check("R1 mask0", 6'h18, 32'h0);
        rd_check("R1 mask1", 6'h10, 32'h0);
        rd_check("R1 mask2", 6'h14, 32'h0);
        rd_check("R1 fastctl", 6'h0C, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);
        check("R1 fast_o", {31'h0, fast_o}, 32'h0);

        // R2: set/clear semantics
        drive(8'h00, 32'h0, 32'h0);
        wr(6'h10, 32'h0000_00F0);
        rd_check("R2 set readback", 6'h10, 32'h0000_00F0);
        rd_check("R2 clr addr readback", 6'h1C, 32'h0000_00F0);
        wr(6'h1C, 32'h0000_0030);
        rd_check("R2 clear", 6'h1C, 32'h0000_00C0);
        wr(6'h18, 32'hFFFF_FFFF);
        rd_check("R2 bank0 width", 6'h18, 32'h0000_00FF);

        // R3: bank pending word, R5/R6 mirror vs summary
        drive(8'h00, 32'h0000_00FF, 32'h0);
        rd_check("R3 pend1", 6'h04, 32'h0000_00C0);
        rd_check("R5 R6 word0", 6'h00, 32'h0000_0500);

        // R6: small-bank clear does not touch mirror bits
        wr(6'h24, 32'hFFFF_FFFF);
        rd_check("R6 bank0 clear no effect", 6'h00, 32'h0000_0500);
        wr(6'h18, 32'hFFFF_FFFF);
        rd_check("R6 bank0 set no effect", 6'h00, 32'h0000_0500);

        // open everything and walk the table
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h14, 32'hFFFF_FFFF);
        for (int i = 0; i < 10; i++) begin
            drive(VECS[i].b0, VECS[i].b1, VECS[i].b2);
            rd_check("R4 R5 R6 table word0", 6'h00, VECS[i].exp0);
            rd_check("R3 table pend2", 6'h08, VECS[i].b2);
            check("R9 table irq_o", {31'h0, irq_o}, {31'h0, |VECS[i].exp0});
        end

        // R7: selector register
        drive(8'h00, 32'h0, 32'h0);
        wr(6'h0C, 32'hFFFF_FF85);
        rd_check("R7 readback", 6'h0C, 32'h0000_0085);

        // R8/R9: bank 1 source 0 routed
        wr(6'h0C, 32'h0000_0080);
        drive(8'h00, 32'h0000_0001, 32'h0);
        check("R8 b1 fast_o", {31'h0, fast_o}, 32'h1);
        check("R9 routed excluded", {31'h0, irq_o}, 32'h0);
        rd_check("R9 word still shows", 6'h00, 32'h0000_0100);

        // R7: bank 2 source 30 at index 62
        wr(6'h0C, 32'h0000_00BE);
        drive(8'h00, 32'h0, 32'h4000_0000);
        check("R7 b2 fast_o", {31'h0, fast_o}, 32'h1);
        check("R9 mirror excluded", {31'h0, irq_o}, 32'h0);
        drive(8'h01, 32'h0, 32'h4000_0000);
        check("R9 other source irq", {31'h0, irq_o}, 32'h1);

        // R7: small bank source 3 at index 67
        wr(6'h0C, 32'h0000_00C3);
        drive(8'h08, 32'h0, 32'h0);
        check("R7 b0 fast_o", {31'h0, fast_o}, 32'h1);
        check("R9 b0 excluded", {31'h0, irq_o}, 32'h0);

        // R8: out-of-range indexes
        drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(6'h0C, 32'h0000_00C8);
        check("R8 index 72", {31'h0, fast_o}, 32'h0);
        wr(6'h0C, 32'h0000_00FF);
        check("R8 index 127", {31'h0, fast_o}, 32'h0);

        // R8: fast path ignores the mask; disabled selector stays low
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h0C, 32'h0000_0080);
        drive(8'h00, 32'h0000_0001, 32'h0);
        check("R8 mask ignored", {31'h0, fast_o}, 32'h1);
        wr(6'h0C, 32'h0000_0000);
        check("R8 disabled", {31'h0, fast_o}, 32'h0);

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_check("R1 re-reset mask2", 6'h14, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule